// File: doc/BRIEF.md
# Routed Interrupt Source Controller

The block collects 64 interrupt input lines and reports every change in their in-service state to a downstream interrupt controller. Each line has a mask bit and an edge-select bit. A rising input records a raw request. On an unmasked line it also sets the in-service bit. A level-mode line drops its request when the input falls. An edge-mode line keeps its request until software clears it by writing a 1 to its bit in a write-1-to-clear register.

Each change in in-service state becomes an event. The event carries the line's 8-bit vector, taken from a per-line table, and a level bit (1 = assert, 0 = deassert). Events leave on a valid/ready handshake one at a time, lowest line first. A mask write or edge-clear write can change many lines at once. Such a write updates all in-service bits in one cycle, and the events then drain one by one. While any event is still waiting, further register writes are refused, so software sees the block as busy.

A 32-bit register port gives access to the configuration. Reads return data one cycle after the request. The port also exposes identification and status words, and a set of registers that are fixed at constant values.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the mask word is all ones, edge-select, raw-request and in-service are all zero, every vector byte is 0, and `ev_valid` is low.
- R2: A rising input sets the line's raw-request bit. If the line is unmasked, the in-service bit is also set and an event with level 1 and the line's vector is sent. If the line is masked, no event is sent and the in-service bit stays 0.
- R3: On a line whose edge-select bit is 1, a falling input is ignored: the raw-request bit stays set and no event is sent.
- R4: On a level-mode line, a falling input clears raw-request and in-service, and sends a level-0 event with the line's vector. Masked lines are included.
- R5: Writing 1s to the clear register (offset 0x060/0x064) clears raw-request only on lines that are in edge mode and currently requesting. Each such line that was in service sends a level-0 event. Level-mode lines are unchanged.
- R6: A mask write that takes a bit from 1 to 0 on a requesting line sets its in-service bit and sends a level-1 event. When several lines change in one write, the events leave lowest line first. Setting a mask bit on a line that is still requesting leaves its in-service bit set and sends no event.
- R7: The 64-bit registers sit at these offsets: mask 0x020, edge-select 0x040, raw-request 0x0C0 (read only), in-service 0x0E0 (read only). Each is split into two 32-bit halves. Address bit 2 set selects bits 63:32. A write replaces only the selected half. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R8: The vector byte of line n is at offset 0x200+n. It is written from `reg_wdata[7:0]` and read back in bits 7:0.
- R9: Identification words: offset 0x000 reads 0x1A000000. Offset 0x004 reads 0x001F0001, which holds version 0x01 in bits 7:0 and the value 31 in bits 23:16. The polarity words (0x080/0x084) and auto-control words (0x0A0 to 0x0AF) read 0 and ignore writes. The route bytes (0x100+n) read 1.
- R10: An event is held with stable vector and level while `ev_valid` is high and `ev_ready` is low. Only one event is transferred per handshake.
- R11: While `reg_busy` is high, register writes have no effect. Reads still work.
- R12: An access to an undefined offset reads 0 and writes nothing. `reg_err` pulses high one cycle after such an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| reg_err | output | 1 | One-cycle flag for an undefined offset |
| reg_busy | output | 1 | Events pending; writes are refused |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Downstream accepts the event |
| ev_vector | output | 8 | Vector of the line that changed |
| ev_level | output | 1 | 1 = assert, 0 = deassert |

## Verification
A table of single lines drives one line at a time through rise and fall, on both register halves and at the outer line indices 0, 31, 32 and 63. This separates the half selection and the vector indexing from the core request logic. Directed patterns cover these cases:
- Two lines unmasked in one write, which checks the lowest-first ordering.
- Masking a line that is still requesting, which checks that no event is sent.
- An edge line whose fall is ignored and which is later cleared, while a level line shares the same clear word.
- A held `ev_ready`, which exposes any event that changes before its handshake and any write that gets through while the block is busy.

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int          NLINES  = 64,
  parameter int          VW      = 8,
  parameter int          AW      = 10,
  parameter logic [31:0] ID_WORD = 32'h1A00_0000,
  parameter logic [7:0]  ID_VER  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  output logic              reg_busy,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [VW-1:0]     ev_vector,
  output logic              ev_level
);
  localparam int LW = $clog2(NLINES);
  localparam logic [AW-1:0] OFF_ID = 'h000, OFF_MASK = 'h020, OFF_EDGE = 'h040,
    OFF_CLR = 'h060, OFF_POL = 'h080, OFF_AUTO = 'h0A0, OFF_RAW = 'h0C0,
    OFF_ISR = 'h0E0, OFF_ROUTE = 'h100, OFF_VEC = 'h200;

  logic [NLINES-1:0] prev_q, irr_q, isr_q, mask_q, edge_q, sent_q;
  logic [VW-1:0]     vec_q [NLINES];

  wire hi       = reg_addr[2];
  wire hit_id   = reg_addr[AW-1:3] == OFF_ID[AW-1:3];
  wire hit_mask = reg_addr[AW-1:3] == OFF_MASK[AW-1:3];
  wire hit_edge = reg_addr[AW-1:3] == OFF_EDGE[AW-1:3];
  wire hit_clr  = reg_addr[AW-1:3] == OFF_CLR[AW-1:3];
  wire hit_pol  = reg_addr[AW-1:3] == OFF_POL[AW-1:3];
  wire hit_raw  = reg_addr[AW-1:3] == OFF_RAW[AW-1:3];
  wire hit_isr  = reg_addr[AW-1:3] == OFF_ISR[AW-1:3];
  wire hit_auto = reg_addr[AW-1:4] == OFF_AUTO[AW-1:4];
  wire hit_rte  = reg_addr[AW-1:LW] == OFF_ROUTE[AW-1:LW];
  wire hit_vec  = reg_addr[AW-1:LW] == OFF_VEC[AW-1:LW];
  wire defined  = hit_id | hit_mask | hit_edge | hit_clr | hit_pol | hit_raw |
                  hit_isr | hit_auto | hit_rte | hit_vec;
  wire [LW-1:0] idx = reg_addr[LW-1:0];

  wire wr_ok  = reg_wr & ~reg_busy;
  wire wr_clr = wr_ok & hit_clr;
  wire [NLINES-1:0] hsel = {{(NLINES/2){hi}}, {(NLINES/2){~hi}}};
  wire [NLINES-1:0] wide = {reg_wdata, reg_wdata};

  function automatic logic [31:0] half32(input logic [NLINES-1:0] x, input logic h);
    return h ? x[NLINES-1:NLINES/2] : x[NLINES/2-1:0];
  endfunction

  wire [NLINES-1:0] rise   = irq_in & ~prev_q;
  wire [NLINES-1:0] fall   = ~irq_in & prev_q & ~edge_q;
  wire [NLINES-1:0] irr_a  = (irr_q | rise) & ~fall;
  wire [NLINES-1:0] isr_a  = (isr_q | (rise & ~mask_q)) & ~fall;
  wire [NLINES-1:0] mask_n = (wr_ok & hit_mask) ? ((mask_q & ~hsel) | (wide & hsel)) : mask_q;
  wire [NLINES-1:0] opened = mask_q & ~mask_n;
  wire [NLINES-1:0] closed = ~mask_q & mask_n;
  wire [NLINES-1:0] clr    = wr_clr ? (wide & hsel & edge_q & irr_a) : '0;
  wire [NLINES-1:0] irr_n  = irr_a & ~clr;
  wire [NLINES-1:0] isr_n  = (isr_a | (irr_a & opened)) & ~(closed & ~irr_a) & ~clr;

  wire [NLINES-1:0] pend = isr_q ^ sent_q;
  logic [LW-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (pend[i]) pick = LW'(i);
  end
  wire load = (|pend) & (~ev_valid | ev_ready);
  assign reg_busy = (|pend) | ev_valid;

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hit_id)        rd_val = hi ? {8'h00, 8'd31, 8'h00, ID_VER} : ID_WORD;
    else if (hit_mask) rd_val = half32(mask_q, hi);
    else if (hit_edge) rd_val = half32(edge_q, hi);
    else if (hit_raw)  rd_val = half32(irr_q, hi);
    else if (hit_isr)  rd_val = half32(isr_q, hi);
    else if (hit_rte)  rd_val = 32'd1;
    else if (hit_vec)  rd_val = 32'(vec_q[idx]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0; irr_q <= '0; isr_q <= '0; sent_q <= '0;
      mask_q <= '1; edge_q <= '0;
      ev_valid <= 1'b0; ev_vector <= '0; ev_level <= 1'b0;
      reg_rdata <= '0; reg_err <= 1'b0;
      for (int i = 0; i < NLINES; i++) vec_q[i] <= '0;
    end else begin
      prev_q <= irq_in;
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      mask_q <= mask_n;
      if (wr_ok & hit_edge) edge_q <= (edge_q & ~hsel) | (wide & hsel);
      if (wr_ok & hit_vec)  vec_q[idx] <= reg_wdata[VW-1:0];
      if (load) begin
        ev_valid     <= 1'b1;
        ev_vector    <= vec_q[pick];
        ev_level     <= isr_q[pick];
        sent_q[pick] <= isr_q[pick];
      end else if (ev_ready) begin
        ev_valid <= 1'b0;
      end
      if (reg_rd) reg_rdata <= rd_val;
      reg_err <= (reg_wr | reg_rd) & ~defined;
    end
  end
endmodule

module irq_route_ctrl_chk #(
  parameter int NL = 64,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          reg_busy,
  input logic          reg_err,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic [VW-1:0] ev_vector,
  input logic          ev_level,
  input logic [NL-1:0] irr,
  input logic [NL-1:0] isr,
  input logic [NL-1:0] edgesel,
  input logic [NL-1:0] mask,
  input logic          wr_clr
);
  p_isr_within_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (isr & ~irr) == '0);

  p_event_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_vector) && $stable(ev_level));

  p_edge_request_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ($past(irr & edgesel) & ~irr) == '0);

  p_busy_write_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_busy |=> $stable(mask) && $stable(edgesel));

  p_err_follows_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> $past(reg_wr || reg_rd));
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NL(NLINES), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_busy(reg_busy),
  .reg_err(reg_err), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_vector(ev_vector),
  .ev_level(ev_level), .irr(irr_q), .isr(isr_q), .edgesel(edge_q), .mask(mask_q),
  .wr_clr(wr_clr)
);

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;
  localparam logic [9:0] A_ID = 'h000, A_MASK = 'h020, A_EDGE = 'h040, A_CLR = 'h060,
    A_POL = 'h080, A_AUTO = 'h0A0, A_RAW = 'h0C0, A_ISR = 'h0E0, A_ROUTE = 'h100, A_VEC = 'h200;
  localparam int NT = 6;
  localparam logic [13:0] TBL [NT] = '{
    {6'd0, 8'h11}, {6'd1, 8'h22}, {6'd31, 8'h3C},
    {6'd32, 8'h47}, {6'd45, 8'h80}, {6'd63, 8'hFF}};

  logic clk = 0, rst_n = 0;
  logic [63:0] irq_in = '0;
  logic reg_wr = 0, reg_rd = 0, ev_ready = 1;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_err, reg_busy, ev_valid, ev_level;
  logic [7:0] ev_vector;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] ev_q [$];

  always #2 clk = ~clk;

  irq_route_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .reg_busy(reg_busy), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_vector(ev_vector),
    .ev_level(ev_level));

  always @(posedge clk)
    if (rst_n && ev_valid && ev_ready) ev_q.push_back({ev_level, ev_vector});

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_now(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    while (reg_busy) @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata; e = reg_err;
  endtask

  task automatic rchk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d; logic e;
    rd(a, d, e);
    chk(tag, d, exp);
  endtask

  task automatic expect_ev(input string tag, input logic lvl, input logic [7:0] vec);
    int n = 0;
    while (ev_q.size() == 0 && n < 100) begin @(negedge clk); n++; end
    if (ev_q.size() == 0) chk({tag, " event missing"}, 32'h0, {23'h0, lvl, vec});
    else chk(tag, 32'(ev_q.pop_front()), {23'h0, lvl, vec});
  endtask

  task automatic expect_quiet(input string tag);
    repeat (10) @(negedge clk);
    chk(tag, 32'(ev_q.size()), 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 ev_valid", 32'(ev_valid), 0);
    rchk("R1 mask lo", A_MASK, 32'hFFFF_FFFF);
    rchk("R1 mask hi", A_MASK + 4, 32'hFFFF_FFFF);
    rchk("R1 edge lo", A_EDGE, 0);
    rchk("R1 raw hi", A_RAW + 4, 0);
    rchk("R1 isr lo", A_ISR, 0);
    rchk("R1 vector", A_VEC + 7, 0);

    wr(A_MASK, 0);
    wr(A_MASK + 4, 0);
    for (int k = 0; k < NT; k++) begin
      int ln = int'(TBL[k][13:8]);
      logic [7:0] v = TBL[k][7:0];
      logic [9:0] hoff = (ln >= 32) ? 10'd4 : 10'd0;
      logic [31:0] bitv = 32'd1 << (ln % 32);
      wr(A_VEC + 10'(ln), {24'h0, v});
      rchk("R8 vector readback", A_VEC + 10'(ln), {24'h0, v});
      @(negedge clk); irq_in[ln] = 1;
      expect_ev("R2 assert", 1, v);
      rchk("R2 raw", A_RAW + hoff, bitv);
      rchk("R2 isr", A_ISR + hoff, bitv);
      @(negedge clk); irq_in[ln] = 0;
      expect_ev("R4 deassert", 0, v);
      rchk("R4 raw cleared", A_RAW + hoff, 0);
    end

    // R2 masked rise
    wr(A_MASK, 32'h0000_0220);
    wr(A_VEC + 5, 32'h55);
    wr(A_VEC + 9, 32'h99);
    @(negedge clk); irq_in[5] = 1; irq_in[9] = 1;
    expect_quiet("R2 masked no event");
    rchk("R2 masked raw", A_RAW, 32'h220);
    rchk("R2 masked isr", A_ISR, 0);
    // R6 unmask two lines, lowest first
    wr(A_MASK, 0);
    expect_ev("R6 first", 1, 8'h55);
    expect_ev("R6 second", 1, 8'h99);
    rchk("R6 isr", A_ISR, 32'h220);
    wr(A_MASK, 32'h0000_0220);
    expect_quiet("R6 remask no event");
    rchk("R6 remask isr kept", A_ISR, 32'h220);
    // R4 masked lines still deassert on fall
    @(negedge clk); irq_in[5] = 0; irq_in[9] = 0;
    expect_ev("R4 masked fall a", 0, 8'h55);
    expect_ev("R4 masked fall b", 0, 8'h99);
    wr(A_MASK, 0);

    // R3 / R5 edge mode and clear
    wr(A_EDGE, 32'h0000_1000);
    wr(A_VEC + 12, 32'hC1);
    wr(A_VEC + 2, 32'h2B);
    @(negedge clk); irq_in[12] = 1;
    expect_ev("R3 edge assert", 1, 8'hC1);
    @(negedge clk); irq_in[12] = 0;
    expect_quiet("R3 fall ignored");
    rchk("R3 raw kept", A_RAW, 32'h1000);
    @(negedge clk); irq_in[2] = 1;
    expect_ev("R5 level assert", 1, 8'h2B);
    wr(A_CLR, 32'h0000_1004);
    expect_ev("R5 clear deassert", 0, 8'hC1);
    expect_quiet("R5 level untouched");
    rchk("R5 raw after clear", A_RAW, 32'h0000_0004);
    @(negedge clk); irq_in[2] = 0;
    expect_ev("R5 level fall", 0, 8'h2B);

    // R7 halves
    wr(A_EDGE + 4, 32'h8000_0001);
    rchk("R7 lo untouched", A_EDGE, 32'h0000_1000);
    rchk("R7 hi written", A_EDGE + 4, 32'h8000_0001);
    wr(A_EDGE + 4, 0);

    // R9 identification and fixed registers
    rchk("R9 id lo", A_ID, 32'h1A00_0000);
    rchk("R9 id hi", A_ID + 4, 32'h001F_0001);
    wr(A_POL, 32'hFFFF_FFFF);
    rchk("R9 polarity", A_POL, 0);
    wr(A_AUTO + 8, 32'h1234_5678);
    rchk("R9 auto", A_AUTO + 8, 0);
    wr(A_ROUTE + 3, 0);
    rchk("R9 route", A_ROUTE + 3, 1);

    // R12 undefined offsets
    begin
      logic [31:0] d; logic e;
      rd(10'h300, d, e);
      chk("R12 read data", d, 0);
      chk("R12 err pulse", 32'(e), 1);
      @(negedge clk);
      chk("R12 err one cycle", 32'(reg_err), 0);
      wr(10'h3F0, 32'h0);
      chk("R12 err on write", 32'(reg_err), 1);
      rchk("R12 mask unaffected", A_MASK, 0);
    end

    // R10 / R11 backpressure and busy
    wr(A_VEC + 20, 32'hA0);
    wr(A_VEC + 21, 32'hA1);
    @(negedge clk); ev_ready = 0; irq_in[20] = 1; irq_in[21] = 1;
    repeat (5) @(negedge clk);
    chk("R10 valid", 32'(ev_valid), 1);
    chk("R10 vector", 32'(ev_vector), 32'hA0);
    repeat (3) @(negedge clk);
    chk("R10 held", {23'h0, ev_level, ev_vector}, 32'h1A0);
    wr_now(A_VEC + 0, 32'hEE);
    rchk("R11 write blocked", A_VEC + 0, 32'h11);
    @(negedge clk); ev_ready = 1;
    expect_ev("R10 first", 1, 8'hA0);
    expect_ev("R10 second", 1, 8'hA1);
    @(negedge clk); irq_in[20] = 0; irq_in[21] = 0;
    expect_ev("R4 drop a", 0, 8'hA0);
    expect_ev("R4 drop b", 0, 8'hA1);
    expect_quiet("R10 drained");

    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule